// File: doc/BRIEF.md
# Display List Instruction Sequencer

This block walks a display list held in memory and turns each one-byte instruction into the decoded fields that a raster video controller needs for one mode line. It issues a read strobe with an address, captures the returned byte one cycle later, and decodes it. When an instruction carries operands, it fetches two more bytes. It then holds the result until the raster side reports that the mode line has ended.

An instruction byte packs a mode number into its low nibble and option flags into its upper nibble. Mode zero produces a run of blank lines. Mode one is a jump, and one jump variant parks the sequencer until the next frame begins. Modes two to fifteen are display modes, and these may reload the memory scan address. The instruction pointer steps only inside an aligned 1 KB window.

Fetching is gated by a display-list DMA enable input. When that input is low, the block freezes wherever it stands in its sequence.

Top module: `dl_sequencer`

## Requirements
- R1: After reset, no read is issued while `dl_dma_en` is low, and the outputs are as follows: `vb_wait`=0, `line_active`=0, `mode_num`=0, `blank_lines`=1, `scan_addr`=0. The first fetch after reset reads address `RESET_PTR`.
- R2: Each read drives `mem_rd` high for exactly one cycle with `mem_addr` equal to the pointer. The byte on `mem_data` is captured in the following cycle. Successive reads use successive pointer values.
- R3: The instruction byte decodes as follows. Bit 7 drives `dli_req`. Bits 3..0 drive `mode_num`. Bit 5 drives `vscroll_en` and bit 4 drives `hscroll_en`, but only for modes 2..15; in modes 0 and 1 both enables read 0.
- R4: In mode 0, `blank_lines` equals bits 6..4 plus one (range 1 to 8) and no operand bytes are read. In every other mode, `blank_lines` is 0.
- R5: A mode 2..15 instruction with bit 6 set reads two operand bytes, low byte first. The 16-bit value formed from them is placed on `scan_addr`, which keeps its value at all other times.
- R6: A mode 1 instruction reads two operand bytes, low byte first, and loads the whole pointer from them. Without bit 6 set, the next instruction fetch follows at once, at the target, with no mode line in between.
- R7: A mode 1 instruction with bit 6 set (byte 0x41) loads the pointer and then raises `vb_wait`. No read is issued until `frame_start` arrives. The next fetch is then at the jump target. A `frame_start` at any other time has no effect.
- R8: Pointer steps change only the low 10 bits, which wrap from 0x3FF to 0x000. The upper bits stay unchanged.
- R9: `mem_rd` is never high while `dl_dma_en` is low. A fetch that is held back this way resumes at the same address once `dl_dma_en` returns high.
- R10: After an instruction other than a jump has been decoded, `line_active` stays high and the decoded fields stay unchanged until `line_done`. The next instruction fetch follows then. A `line_done` outside an active line is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Start-of-frame (vertical blank) pulse |
| line_done | input | 1 | End of the current mode line |
| dl_dma_en | input | 1 | Display-list fetch enable |
| mem_rd | output | 1 | Read strobe |
| mem_addr | output | ADDR_W | Read address (instruction pointer) |
| mem_data | input | 8 | Read data, valid the cycle after `mem_rd` |
| mode_num | output | 4 | Decoded mode number |
| dli_req | output | 1 | Display-list interrupt request flag |
| vscroll_en | output | 1 | Vertical scroll enable |
| hscroll_en | output | 1 | Horizontal scroll enable |
| blank_lines | output | 4 | Blank line count for mode 0, else 0 |
| scan_addr | output | ADDR_W | Memory scan address last loaded |
| vb_wait | output | 1 | Parked until the next frame start |
| line_active | output | 1 | Decoded instruction held for a mode line |

## Verification
The bench drives a list that places instructions across the 1 KB window edge. A design that carried the increment into bit 10 would jump to the wrong window and read bytes that do not belong to the list. The list contains both jump forms. A design that decoded the wait variant from the wrong bit would either stall on a plain jump or run straight past the end of the frame. Frame-start and line-done pulses arrive in every state, and the DMA enable drops in the middle of operand fetches. These catch a sequencer that acts on stray pulses, that loses operand order, or that strobes memory while disabled. The scroll enables are checked on blank and jump instructions whose bits 5..4 are really count or flag bits, which catches a decoder that does not gate them by mode.

// File: rtl/dlseq_pkg.sv
`timescale 1ns/1ps
package dlseq_pkg;

  typedef enum logic [2:0] {
    ST_OP_REQ,
    ST_OP_CAP,
    ST_LO_REQ,
    ST_LO_CAP,
    ST_HI_REQ,
    ST_HI_CAP,
    ST_LINE,
    ST_VBWAIT
  } seq_state_e;

  typedef struct packed {
    logic [3:0] mode;
    logic       irq;
    logic       vscroll;
    logic       hscroll;
    logic [3:0] blank_lines;
    logic       has_operands;
    logic       is_jump;
    logic       jump_waits;
  } dl_fields_t;

endpackage

// File: rtl/dlseq_decode.sv
`timescale 1ns/1ps
module dlseq_decode
  import dlseq_pkg::*;
(
  input  logic [7:0] op,
  output dl_fields_t fields
);

  logic is_blank;
  logic is_disp;

  always_comb begin
    is_blank            = (op[3:0] == 4'd0);
    is_disp             = (op[3:0] >= 4'd2);
    fields.mode         = op[3:0];
    fields.irq          = op[7];
    fields.vscroll      = is_disp & op[5];
    fields.hscroll      = is_disp & op[4];
    fields.blank_lines  = is_blank ? ({1'b0, op[6:4]} + 4'd1) : 4'd0;
    fields.is_jump      = (op[3:0] == 4'd1);
    fields.jump_waits   = fields.is_jump & op[6];
    fields.has_operands = fields.is_jump | (is_disp & op[6]);
  end

endmodule

// File: rtl/dlseq_ptr.sv
`timescale 1ns/1ps
module dlseq_ptr #(
  parameter int unsigned          ADDR_W    = 16,
  parameter int unsigned          WIN_W     = 10,
  parameter logic [ADDR_W-1:0]    RESET_PTR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] ptr
);

  localparam int unsigned HI_W = ADDR_W - WIN_W;

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [WIN_W-1:0]  low_inc;

  always_comb begin
    low_inc = ptr_q[WIN_W-1:0] + 1'b1;
    ptr_d   = ptr_q;
    if (load)      ptr_d = load_val;
    else if (step) ptr_d = {ptr_q[ADDR_W-1:WIN_W], low_inc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ptr_q <= RESET_PTR;
    else if (load || step)   ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R8: a step keeps the window and advances the low bits modulo the window
  a_r8_window_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=>
      (ptr[ADDR_W-1:WIN_W] == HI_W'($past(ptr[ADDR_W-1:WIN_W]))) &&
      (ptr[WIN_W-1:0] == WIN_W'($past(ptr[WIN_W-1:0]) + 1'b1)));

endmodule

// File: rtl/dlseq_ctrl.sv
`timescale 1ns/1ps
module dlseq_ctrl
  import dlseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic line_done,
  input  logic dma_en,
  input  logic cap_needs_ops,
  input  logic held_is_jump,
  input  logic held_waits,
  output logic mem_rd,
  output logic op_cap,
  output logic lo_cap,
  output logic hi_cap,
  output logic vb_wait,
  output logic line_active
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    mem_rd  = 1'b0;
    op_cap  = 1'b0;
    lo_cap  = 1'b0;
    hi_cap  = 1'b0;
    case (state_q)
      ST_OP_REQ: if (dma_en) begin mem_rd = 1'b1; state_d = ST_OP_CAP; end
      ST_OP_CAP: begin
        op_cap  = 1'b1;
        state_d = cap_needs_ops ? ST_LO_REQ : ST_LINE;
      end
      ST_LO_REQ: if (dma_en) begin mem_rd = 1'b1; state_d = ST_LO_CAP; end
      ST_LO_CAP: begin lo_cap = 1'b1; state_d = ST_HI_REQ; end
      ST_HI_REQ: if (dma_en) begin mem_rd = 1'b1; state_d = ST_HI_CAP; end
      ST_HI_CAP: begin
        hi_cap = 1'b1;
        if (held_is_jump) state_d = held_waits ? ST_VBWAIT : ST_OP_REQ;
        else              state_d = ST_LINE;
      end
      ST_LINE:   if (line_done)   state_d = ST_OP_REQ;
      ST_VBWAIT: if (frame_start) state_d = ST_OP_REQ;
      default:   state_d = ST_OP_REQ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OP_REQ;
    else        state_q <= state_d;
  end

  assign vb_wait     = (state_q == ST_VBWAIT);
  assign line_active = (state_q == ST_LINE);

  // R9: no strobe without the enable
  a_r9_rd_needs_dma: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> dma_en);
  // R2: a strobe lasts one cycle, the next cycle is the capture
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  // R7: parked means silent on the memory port
  a_r7_no_fetch_parked: assert property (@(posedge clk) disable iff (!rst_n)
    vb_wait |-> !mem_rd);
  // R7: only frame_start releases the park
  a_r7_hold_park: assert property (@(posedge clk) disable iff (!rst_n)
    (vb_wait && !frame_start) |=> vb_wait);

endmodule

// File: rtl/dl_sequencer.sv
`timescale 1ns/1ps
module dl_sequencer
  import dlseq_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       WIN_W     = 10,
  parameter logic [ADDR_W-1:0] RESET_PTR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_done,
  input  logic              dl_dma_en,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_data,
  output logic [3:0]        mode_num,
  output logic              dli_req,
  output logic              vscroll_en,
  output logic              hscroll_en,
  output logic [3:0]        blank_lines,
  output logic [ADDR_W-1:0] scan_addr,
  output logic              vb_wait,
  output logic              line_active
);

  localparam int unsigned OPND_W = ADDR_W - 8;

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [7:0]        op_q;
  logic [7:0]        lo_q;
  logic [ADDR_W-1:0] scan_q;
  logic              op_cap, lo_cap, hi_cap;
  logic              ptr_step, ptr_load, scan_load;
  logic [ADDR_W-1:0] operand_val;
  dl_fields_t        raw_f, held_f;

  // reset asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  dlseq_decode u_dec_raw  (.op(mem_data), .fields(raw_f));
  dlseq_decode u_dec_held (.op(op_q),     .fields(held_f));

  dlseq_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .frame_start  (frame_start),
    .line_done    (line_done),
    .dma_en       (dl_dma_en),
    .cap_needs_ops(raw_f.has_operands),
    .held_is_jump (held_f.is_jump),
    .held_waits   (held_f.jump_waits),
    .mem_rd       (mem_rd),
    .op_cap       (op_cap),
    .lo_cap       (lo_cap),
    .hi_cap       (hi_cap),
    .vb_wait      (vb_wait),
    .line_active  (line_active)
  );

  assign operand_val = {OPND_W'(mem_data), lo_q};
  assign ptr_load    = hi_cap & held_f.is_jump;
  assign scan_load   = hi_cap & ~held_f.is_jump;
  assign ptr_step    = op_cap | lo_cap | scan_load;

  dlseq_ptr #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .RESET_PTR(RESET_PTR)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .step    (ptr_step),
    .load    (ptr_load),
    .load_val(operand_val),
    .ptr     (mem_addr)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  op_q <= 8'h00;
    else if (op_cap) op_q <= mem_data;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  lo_q <= 8'h00;
    else if (lo_cap) lo_q <= mem_data;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)     scan_q <= '0;
    else if (scan_load) scan_q <= operand_val;
  end

  assign mode_num    = held_f.mode;
  assign dli_req     = held_f.irq;
  assign vscroll_en  = held_f.vscroll;
  assign hscroll_en  = held_f.hscroll;
  assign blank_lines = held_f.blank_lines;
  assign scan_addr   = scan_q;

  // R10: a held mode line keeps its fields until line_done
  a_r10_line_holds: assert property (@(posedge clk) disable iff (!rst_int_n)
    (line_active && !line_done) |=> (line_active && $stable(mode_num) && $stable(dli_req)));
  // R3: scroll enables never set outside display modes
  a_r3_scroll_gated: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_num < 4'd2) |-> (!vscroll_en && !hscroll_en));
  // R4: blank count range and exclusivity
  a_r4_blank_range: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_num == 4'd0) ? (blank_lines >= 4'd1 && blank_lines <= 4'd8) : (blank_lines == 4'd0));
  // R5: scan address moves only after an operand-bearing display instruction
  a_r5_scan_only_on_load: assert property (@(posedge clk) disable iff (!rst_int_n)
    (scan_addr != $past(scan_addr)) |-> (mode_num >= 4'd2 && line_active));

endmodule

// File: tb/tb_dl_sequencer.sv
`timescale 1ns/1ps
module tb_dl_sequencer;

  localparam logic [15:0] START = 16'h13F9;

  logic        clk = 1'b0;
  logic        rst_n, frame_start, line_done, dl_dma_en;
  logic        mem_rd, dli_req, vscroll_en, hscroll_en, vb_wait, line_active;
  logic [15:0] mem_addr, scan_addr;
  logic [7:0]  mem_data;
  logic [3:0]  mode_num, blank_lines;

  always #10 clk = ~clk;

  dl_sequencer #(.ADDR_W(16), .WIN_W(10), .RESET_PTR(START)) dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_done(line_done),
    .dl_dma_en(dl_dma_en), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
    .mode_num(mode_num), .dli_req(dli_req), .vscroll_en(vscroll_en),
    .hscroll_en(hscroll_en), .blank_lines(blank_lines), .scan_addr(scan_addr),
    .vb_wait(vb_wait), .line_active(line_active)
  );

  logic [7:0] lst [int];
  int checks = 0, fails = 0;
  int wrap_hits = 0, park_hits = 0, lms_hits = 0;
  bit done = 0;

  function automatic logic [7:0] rdmem(int a);
    return lst.exists(a) ? lst[a] : 8'h00;
  endfunction

  // memory: registered read
  always @(posedge clk) if (mem_rd) mem_data <= rdmem(int'(mem_addr));

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_phase, m_ptr, m_op, m_lo, m_scan, rel_cnt;
  bit m_run;

  function automatic int step_ptr(int p);
    return (p & 'hFC00) | ((p + 1) & 'h3FF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) rel_cnt = 0;
    if (!rst_n || rel_cnt < 2) begin
      if (rst_n) rel_cnt++;
      m_phase = 0; m_ptr = int'(START); m_op = 0; m_lo = 0; m_scan = 0;
    end else begin
      case (m_phase)
        0: if (dl_dma_en) m_phase = 1;
        1: begin
          m_op  = int'(rdmem(m_ptr));
          m_ptr = step_ptr(m_ptr);
          if ((m_op & 15) == 1 || ((m_op & 15) >= 2 && (m_op & 64) != 0)) m_phase = 2;
          else m_phase = 6;
        end
        2: if (dl_dma_en) m_phase = 3;
        3: begin m_lo = int'(rdmem(m_ptr)); m_ptr = step_ptr(m_ptr); m_phase = 4; end
        4: if (dl_dma_en) m_phase = 5;
        5: begin
          if ((m_op & 15) == 1) begin
            m_ptr   = (int'(rdmem(m_ptr)) << 8) | m_lo;
            m_phase = ((m_op & 64) != 0) ? 7 : 0;
          end else begin
            m_scan  = (int'(rdmem(m_ptr)) << 8) | m_lo;
            m_ptr   = step_ptr(m_ptr);
            m_phase = 6;
          end
        end
        6: if (line_done) m_phase = 0;
        default: if (frame_start) m_phase = 0;
      endcase
    end
  end

  // compare every cycle, midway between the falling and rising edges
  always @(negedge clk) begin
    #5;
    if (m_run) begin
      int md;
      bit ers, disp;
      md   = m_op & 15;
      disp = (md >= 2);
      ers  = (m_phase == 0 || m_phase == 2 || m_phase == 4) && dl_dma_en && rel_cnt >= 2;
      chk(mem_rd == ers, dl_dma_en ? "R2" : "R9", "mem_rd", int'(mem_rd), int'(ers));
      if (ers) begin
        chk(int'(mem_addr) == m_ptr, "R6", "mem_addr", int'(mem_addr), m_ptr);
        if (mem_addr == 16'h1000) wrap_hits++;
      end
      chk(int'(mode_num) == md, "R3", "mode_num", int'(mode_num), md);
      chk(int'(dli_req) == ((m_op >> 7) & 1), "R3", "dli_req", int'(dli_req), (m_op >> 7) & 1);
      chk(int'(vscroll_en) == (disp ? ((m_op >> 5) & 1) : 0), "R3", "vscroll_en",
          int'(vscroll_en), disp ? ((m_op >> 5) & 1) : 0);
      chk(int'(hscroll_en) == (disp ? ((m_op >> 4) & 1) : 0), "R3", "hscroll_en",
          int'(hscroll_en), disp ? ((m_op >> 4) & 1) : 0);
      chk(int'(blank_lines) == ((md == 0) ? ((m_op >> 4) & 7) + 1 : 0), "R4", "blank_lines",
          int'(blank_lines), (md == 0) ? ((m_op >> 4) & 7) + 1 : 0);
      chk(int'(scan_addr) == m_scan, "R5", "scan_addr", int'(scan_addr), m_scan);
      if (m_scan == 'h1234) lms_hits++;
      chk(vb_wait == (m_phase == 7), "R7", "vb_wait", int'(vb_wait), int'(m_phase == 7));
      if (vb_wait) park_hits++;
      chk(line_active == (m_phase == 6), "R10", "line_active", int'(line_active), int'(m_phase == 6));
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    lst[32'h13F9] = 8'h70;                                          // blank x8
    lst[32'h13FA] = 8'h42; lst[32'h13FB] = 8'h00; lst[32'h13FC] = 8'h40; // mode 2, scan 4000
    lst[32'h13FD] = 8'h02;
    lst[32'h13FE] = 8'hB5;                                          // irq, vs, hs, mode 5
    lst[32'h13FF] = 8'h1F;                                          // hs, mode F
    lst[32'h1000] = 8'h06;                                          // after window wrap
    lst[32'h1001] = 8'hC4; lst[32'h1002] = 8'h34; lst[32'h1003] = 8'h12; // irq, scan 1234
    lst[32'h1004] = 8'h01; lst[32'h1005] = 8'h00; lst[32'h1006] = 8'h11; // jump 1100
    lst[32'h1100] = 8'h30;                                          // blank x4, bits 5..4 set
    lst[32'h1101] = 8'h80;                                          // blank x1 with irq
    lst[32'h1102] = 8'h41; lst[32'h1103] = 8'hF9; lst[32'h1104] = 8'h13; // jump and park

    m_run = 0;
    rst_n = 0; frame_start = 0; line_done = 0; dl_dma_en = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #5;
    // R1: reset state seen at the ports
    chk(mem_rd == 1'b0,       "R1", "mem_rd",      int'(mem_rd), 0);
    chk(vb_wait == 1'b0,      "R1", "vb_wait",     int'(vb_wait), 0);
    chk(line_active == 1'b0,  "R1", "line_active", int'(line_active), 0);
    chk(mode_num == 4'd0,     "R1", "mode_num",    int'(mode_num), 0);
    chk(blank_lines == 4'd1,  "R1", "blank_lines", int'(blank_lines), 1);
    chk(scan_addr == 16'h0,   "R1", "scan_addr",   int'(scan_addr), 0);
    chk(mem_addr == START,    "R1", "mem_addr",    int'(mem_addr), int'(START));
    m_run = 1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      line_done   = ((i % 5) == 3) || ((i % 13) == 0);
      frame_start = ((i % 41) == 7);
      dl_dma_en   = !(((i % 37) >= 20) && ((i % 37) <= 26));
    end
    @(negedge clk);
    chk(wrap_hits > 0, "R8", "fetches at 1000 after 13FF", wrap_hits, 1);
    chk(park_hits > 0, "R7", "cycles parked", park_hits, 1);
    chk(lms_hits > 0,  "R5", "cycles with scan 1234", lms_hits, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run did not finish actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule